// File: doc/BRIEF.md
# Calendar Counter with Daylight Saving

This block keeps wall-clock time and a calendar. Each cycle in which the one-pulse-per-second enable is high, the block advances seconds, minutes, hours, day of week, date, month and a two-digit year. It handles month lengths and leap years. A mode input selects how every register is stored: as a plain binary value or as two packed decimal digits. A second mode input selects a 24-hour clock, or a 12-hour clock that carries an afternoon flag.

When daylight saving is enabled, the hour counter applies two adjustments. In spring it skips the hour after 1:59:59 AM. In autumn it repeats that hour once. A one-bit memory prevents the repeated hour from repeating again. Software sets the time through a register load port, which takes a register index and a data byte. The block does not convert stored values when a mode input changes, so software reloads the registers after changing a mode. A one-cycle pulse follows every accepted advance.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the registers hold 00 seconds, 00 minutes, day of week 1 (Sunday), date 1, month 1 and year 00. The hour is 00 in 24-hour mode. In 12-hour mode the hour reads 12 AM, which is 0x12 in BCD or 0x0C in binary, with bit 7 clear. upd_done is low.
- R2: Each accepted tick adds one second. Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into the hour.
- R3: With bcd_mode=1 each register holds tens in bits [7:4] and units in bits [3:0]. With bcd_mode=0 each register holds the plain binary value.
- R4: With hr24=1 the hour runs from 0 to 23. 23:59:59 becomes 00:00:00 and the day advances.
- R5: With hr24=0 the hour register has PM in bit 7 and the hour (1 to 12) in bits [6:0]. The sequence is 12, 1, …, 11. PM toggles when 11 becomes 12. 11:59:59 PM becomes 12:00:00 AM and the day advances.
- R6: On a day advance, day of week goes from 7 to 1 and otherwise adds one. Date returns to 1 after the last day of the month. Months 4, 6, 9 and 11 have 30 days and the other months have 31. February has 29 days when the year is divisible by 4 and 28 otherwise. Month 12 wraps to 1 and adds one to the year. Year 99 wraps to 0.
- R7: With dst_en=1, month 4, day of week 1 and date 7 or less, 1:59:59 AM is followed by 3:00:00 AM.
- R8: With dst_en=1, month 10, day of week 1 and date 25 or more, the first 1:59:59 AM is followed by 1:00:00 AM. The next 1:59:59 AM is followed by 2:00:00 AM. The fall-back memory clears on a day advance and on a load of the date register.
- R9: With dst_en=0, 1:59:59 AM is always followed by 2:00:00 AM.
- R10: upd_done is high for exactly the one cycle after each accepted tick and low at all other times.
- R11: When ld_en=1, ld_data is written to the register that ld_sel selects, and the new value shows on the outputs the next cycle. The ld_sel encoding is 0 seconds, 1 minutes, 2 hour, 3 day of week, 4 date, 5 month, 6 year; 7 writes nothing. A tick in the same cycle is ignored: the counter does not advance and upd_done stays low.
- R12: When neither tick nor ld_en is high, every register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle enable, once per second |
| bcd_mode | input | 1 | 1 selects BCD storage, 0 selects binary storage |
| hr24 | input | 1 | 1 selects the 24-hour clock, 0 selects the 12-hour clock |
| dst_en | input | 1 | Enables the daylight-saving adjustments |
| ld_en | input | 1 | Register write strobe |
| ld_sel | input | 3 | Index of the register to write |
| ld_data | input | 8 | Value to write |
| sec_o | output | 8 | Seconds |
| min_o | output | 8 | Minutes |
| hr_o | output | 8 | Hour, with PM in bit 7 in 12-hour mode |
| dow_o | output | 8 | Day of week, 1 is Sunday |
| date_o | output | 8 | Day of month |
| mon_o | output | 8 | Month |
| yr_o | output | 8 | Year, 00 to 99 |
| upd_done | output | 1 | Pulse that follows each accepted tick |

## Verification
The bench targets the ripple from 23:59:59 on 31 December, year 99, to the start of year 00. It also covers February around years divisible by 4 and 30-day months. A design with a wrong month-length table, or with carries gated incorrectly, stops on an impossible date or misses the year wrap. The bench checks BCD digit carries from 09 to 10 and the 12-hour turns at 11 and 12. A design that mishandles these produces hex values such as 0x0A, or toggles PM at the wrong hour. The bench drives both daylight-saving Sundays with the enable on and off. On the autumn Sunday it repeats 1:59:59. A design without the fall-back memory returns to 1:00 indefinitely, and one that never clears the memory skips the adjustment on the next qualifying day.

// File: rtl/rtc_calendar.sv
module rtc_calendar #(
  parameter logic [7:0] SPRING_MON = 8'd4,
  parameter logic [7:0] AUTUMN_MON = 8'd10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       bcd_mode,
  input  logic       hr24,
  input  logic       dst_en,
  input  logic       ld_en,
  input  logic [2:0] ld_sel,
  input  logic [7:0] ld_data,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hr_o,
  output logic [7:0] dow_o,
  output logic [7:0] date_o,
  output logic [7:0] mon_o,
  output logic [7:0] yr_o,
  output logic       upd_done
);

  function automatic logic [7:0] dec(input logic [7:0] v, input logic b);
    return b ? (8'(v[7:4]) * 8'd10 + 8'(v[3:0])) : v;
  endfunction

  function automatic logic [7:0] enc(input logic [7:0] n, input logic b);
    logic [7:0] t, u;
    t = n / 8'd10;
    u = n % 8'd10;
    return b ? {t[3:0], u[3:0]} : n;
  endfunction

  logic [7:0] sec_q, min_q, hr_q, dow_q, date_q, mon_q, yr_q;
  logic       fb_q, done_q;

  wire b = bcd_mode;
  wire [7:0] s  = dec(sec_q, b);
  wire [7:0] m  = dec(min_q, b);
  wire [7:0] h  = dec({1'b0, hr_q[6:0]}, b);
  wire [7:0] d  = dec(dow_q, b);
  wire [7:0] dt = dec(date_q, b);
  wire [7:0] mo = dec(mon_q, b);
  wire [7:0] y  = dec(yr_q, b);
  wire       pm = ~hr24 & hr_q[7];

  logic [7:0] dim;
  always_comb begin
    case (mo)
      8'd2:                     dim = (y[1:0] == 2'b00) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:  dim = 8'd30;
      default:                  dim = 8'd31;
    endcase
  end

  wire s_w  = s >= 8'd59;
  wire m_w  = m >= 8'd59;
  wire dt_w = dt >= dim;
  wire mo_w = mo >= 8'd12;
  wire one_am = (h == 8'd1) & ~pm;
  wire sunday = d == 8'd1;
  wire spring = dst_en & (mo == SPRING_MON) & sunday & (dt <= 8'd7) & one_am;
  wire autumn = dst_en & (mo == AUTUMN_MON) & sunday & (dt + 8'd7 > dim) & one_am & ~fb_q;

  logic [7:0] h_n, he, hr_nx;
  logic       pm_n, day_c;
  always_comb begin
    h_n   = h + 8'd1;
    pm_n  = pm;
    day_c = 1'b0;
    if (spring)              h_n = 8'd3;
    else if (autumn)         h_n = 8'd1;
    else if (hr24) begin
      if (h >= 8'd23) begin h_n = 8'd0; day_c = 1'b1; end
    end
    else if (h >= 8'd12)     h_n = 8'd1;
    else if (h == 8'd11) begin pm_n = ~pm; day_c = pm; end
    he    = enc(h_n, b);
    hr_nx = hr24 ? he : {pm_n, he[6:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= 8'h00;
      min_q  <= 8'h00;
      hr_q   <= hr24 ? 8'h00 : enc(8'd12, b);
      dow_q  <= 8'h01;
      date_q <= 8'h01;
      mon_q  <= 8'h01;
      yr_q   <= 8'h00;
      fb_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (ld_en) begin
        case (ld_sel)
          3'd0: sec_q  <= ld_data;
          3'd1: min_q  <= ld_data;
          3'd2: hr_q   <= ld_data;
          3'd3: dow_q  <= ld_data;
          3'd4: begin date_q <= ld_data; fb_q <= 1'b0; end
          3'd5: mon_q  <= ld_data;
          3'd6: yr_q   <= ld_data;
          default: ;
        endcase
      end else if (tick) begin
        done_q <= 1'b1;
        sec_q  <= s_w ? 8'h00 : enc(s + 8'd1, b);
        if (s_w) begin
          min_q <= m_w ? 8'h00 : enc(m + 8'd1, b);
          if (m_w) begin
            hr_q <= hr_nx;
            if (autumn) fb_q <= 1'b1;
            if (day_c) begin
              fb_q   <= 1'b0;
              dow_q  <= (d >= 8'd7) ? 8'h01 : enc(d + 8'd1, b);
              date_q <= dt_w ? 8'h01 : enc(dt + 8'd1, b);
              if (dt_w) begin
                mon_q <= mo_w ? 8'h01 : enc(mo + 8'd1, b);
                if (mo_w) yr_q <= (y >= 8'd99) ? 8'h00 : enc(y + 8'd1, b);
              end
            end
          end
        end
      end
    end
  end

  assign sec_o    = sec_q;
  assign min_o    = min_q;
  assign hr_o     = hr_q;
  assign dow_o    = dow_q;
  assign date_o   = date_q;
  assign mon_o    = mon_q;
  assign yr_o     = yr_q;
  assign upd_done = done_q;

endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       bcd_mode,
  input logic       hr24,
  input logic       dst_en,
  input logic       ld_en,
  input logic [2:0] ld_sel,
  input logic [7:0] ld_data,
  input logic [7:0] sec_o,
  input logic [7:0] min_o,
  input logic [7:0] hr_o,
  input logic [7:0] dow_o,
  input logic [7:0] date_o,
  input logic [7:0] mon_o,
  input logic [7:0] yr_o,
  input logic       upd_done
);
  wire       go     = tick & ~ld_en;
  wire [7:0] c59    = bcd_mode ? 8'h59 : 8'd59;
  wire       at_159 = hr24 & (hr_o == 8'h01) & (min_o == c59) & (sec_o == c59);
  wire       spr    = (mon_o == 8'h04) & (dow_o == 8'h01) & (date_o <= 8'h07);

  AST_DONE_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n) go |=> upd_done); // R10
  AST_DONE_ONLY_TICK: assert property (@(posedge clk) disable iff (!rst_n) !go |=> !upd_done); // R10
  AST_SEC_MOVES: assert property (@(posedge clk) disable iff (!rst_n) go |=> sec_o != $past(sec_o)); // R2
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ld_en) |=> ($stable(sec_o) && $stable(min_o) && $stable(hr_o) && $stable(dow_o)
                           && $stable(date_o) && $stable(mon_o) && $stable(yr_o))); // R12
  AST_LOAD_SEC: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && ld_sel == 3'd0) |=> sec_o == $past(ld_data)); // R11
  AST_SPRING_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (go && dst_en && at_159 && spr) |=> hr_o == 8'h03); // R7
  AST_NO_DST: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !dst_en && at_159) |=> hr_o == 8'h02); // R9
endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .bcd_mode(bcd_mode), .hr24(hr24),
  .dst_en(dst_en), .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
  .sec_o(sec_o), .min_o(min_o), .hr_o(hr_o), .dow_o(dow_o), .date_o(date_o),
  .mon_o(mon_o), .yr_o(yr_o), .upd_done(upd_done)
);

// File: tb/rtc_calendar_bench.sv
module rtc_calendar_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, bcd_mode = 1'b1, hr24 = 1'b1, dst_en = 1'b0;
  logic       ld_en = 1'b0;
  logic [2:0] ld_sel = 3'd0;
  logic [7:0] ld_data = 8'h00;
  logic [7:0] sec_o, min_o, hr_o, dow_o, date_o, mon_o, yr_o;
  logic       upd_done;
  int         errors = 0, checks = 0, cycles = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rtc_calendar u_rtc_calendar (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bcd_mode(bcd_mode), .hr24(hr24),
    .dst_en(dst_en), .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
    .sec_o(sec_o), .min_o(min_o), .hr_o(hr_o), .dow_o(dow_o), .date_o(date_o),
    .mon_o(mon_o), .yr_o(yr_o), .upd_done(upd_done)
  );

  // fields: mode {bcd,hr24,dst}, preset yr,mon,date,dow,hr,min,sec, expected same order
  typedef struct packed {
    logic [2:0]  mode;
    logic [55:0] pre;
    logic [55:0] exp;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{3'b010, {8'd21, 8'd6, 8'd15, 8'd3, 8'd10, 8'd20, 8'd30}, {8'd21, 8'd6, 8'd15, 8'd3, 8'd10, 8'd20, 8'd31}},   // R2
    '{3'b110, 56'h99_12_31_07_23_59_59, 56'h00_01_01_01_00_00_00},                                                 // R3 R4 R6
    '{3'b010, {8'd23, 8'd2, 8'd28, 8'd2, 8'd23, 8'd59, 8'd59}, {8'd23, 8'd3, 8'd1, 8'd3, 8'd0, 8'd0, 8'd0}},       // R6
    '{3'b010, {8'd24, 8'd2, 8'd28, 8'd2, 8'd23, 8'd59, 8'd59}, {8'd24, 8'd2, 8'd29, 8'd3, 8'd0, 8'd0, 8'd0}},      // R6
    '{3'b010, {8'd24, 8'd2, 8'd29, 8'd3, 8'd23, 8'd59, 8'd59}, {8'd24, 8'd3, 8'd1, 8'd4, 8'd0, 8'd0, 8'd0}},       // R6
    '{3'b010, {8'd30, 8'd4, 8'd30, 8'd5, 8'd23, 8'd59, 8'd59}, {8'd30, 8'd5, 8'd1, 8'd6, 8'd0, 8'd0, 8'd0}},       // R6
    '{3'b100, 56'h20_03_15_04_11_59_59, 56'h20_03_15_04_92_00_00},                                                 // R5
    '{3'b100, 56'h20_03_15_07_91_59_59, 56'h20_03_16_01_12_00_00},                                                 // R5
    '{3'b000, {8'd20, 8'd3, 8'd15, 8'd4, 8'h8C, 8'd59, 8'd59}, {8'd20, 8'd3, 8'd15, 8'd4, 8'h81, 8'd0, 8'd0}},     // R5
    '{3'b111, 56'h25_04_05_01_01_59_59, 56'h25_04_05_01_03_00_00},                                                 // R7
    '{3'b110, 56'h25_04_05_01_01_59_59, 56'h25_04_05_01_02_00_00},                                                 // R9
    '{3'b111, 56'h25_04_05_02_01_59_59, 56'h25_04_05_02_02_00_00},                                                 // R7
    '{3'b111, 56'h25_10_27_01_01_59_59, 56'h25_10_27_01_01_00_00},                                                 // R8
    '{3'b001, {8'd25, 8'd4, 8'd3, 8'd1, 8'h01, 8'd59, 8'd59}, {8'd25, 8'd4, 8'd3, 8'd1, 8'h03, 8'd0, 8'd0}},       // R7
    '{3'b110, 56'h25_04_05_02_09_59_59, 56'h25_04_05_02_10_00_00},                                                 // R3
    '{3'b010, {8'd25, 8'd4, 8'd5, 8'd2, 8'd9, 8'd59, 8'd59}, {8'd25, 8'd4, 8'd5, 8'd2, 8'd10, 8'd0, 8'd0}}         // R3
  };

  function automatic logic [55:0] regs();
    return {yr_o, mon_o, date_o, dow_o, hr_o, min_o, sec_o};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic [2:0] sel, input logic [7:0] data);
    @(negedge clk);
    ld_en = 1'b1; ld_sel = sel; ld_data = data;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic load_all(input logic [55:0] v);
    for (int i = 0; i < 7; i++) load(3'(6 - i), v[55 - 8*i -: 8]);
  endtask

  task automatic step();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset regs 24h", {8'h0, regs()}, {8'h0, 56'h00_01_01_01_00_00_00});
    check("R1 reset done", {63'h0, upd_done}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    hr24 = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset hour 12h", {56'h0, hr_o}, 64'h12);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      {bcd_mode, hr24, dst_en} = VECS[i].mode;
      load_all(VECS[i].pre);
      step();
      check($sformatf("R2-R9 vector %0d", i), {8'h0, regs()}, {8'h0, VECS[i].exp});
      check("R10 pulse after tick", {63'h0, upd_done}, 64'h1);
      @(negedge clk);
      check("R10 pulse one cycle", {63'h0, upd_done}, 64'h0);
    end

    // R8 fall-back fires once, then re-arms on a date load
    bcd_mode = 1'b1; hr24 = 1'b1; dst_en = 1'b1;
    load_all(56'h25_10_27_01_01_59_59);
    step();
    check("R8 first fall-back", {56'h0, hr_o}, 64'h01);
    load(3'd1, 8'h59); load(3'd0, 8'h59);
    step();
    check("R8 second pass continues", {8'h0, regs()}, {8'h0, 56'h25_10_27_01_02_00_00});
    load(3'd4, 8'h27); load(3'd2, 8'h01); load(3'd1, 8'h59); load(3'd0, 8'h59);
    step();
    check("R8 latch cleared by date load", {56'h0, hr_o}, 64'h01);

    // R11 load beats tick, and index 7 writes nothing
    dst_en = 1'b0;
    load_all(56'h25_05_10_03_08_30_20);
    @(negedge clk);
    ld_en = 1'b1; ld_sel = 3'd0; ld_data = 8'h45; tick = 1'b1;
    @(negedge clk);
    ld_en = 1'b0; tick = 1'b0;
    check("R11 load wins over tick", {8'h0, regs()}, {8'h0, 56'h25_05_10_03_08_30_45});
    check("R11 no pulse on load", {63'h0, upd_done}, 64'h0);
    load(3'd7, 8'hAA);
    check("R11 index 7 ignored", {8'h0, regs()}, {8'h0, 56'h25_05_10_03_08_30_45});

    // R12 hold without tick
    repeat (5) @(negedge clk);
    check("R12 hold", {8'h0, regs()}, {8'h0, 56'h25_05_10_03_08_30_45});
    check("R10 idle low", {63'h0, upd_done}, 64'h0);

    // R2 sixty ticks make one minute
    load(3'd0, 8'h00);
    for (int k = 0; k < 60; k++) step();
    check("R2 sixty ticks", {48'h0, min_o, sec_o}, 64'h31_00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule